// File: doc/BRIEF.md
# Predicated Vector Compare Sequencer

This block takes the integer conditional-branch instruction format and runs it as an element-by-element compare when a source operand is a vector. A 32-bit instruction word is offered with a valid/ready handshake, together with one vector tag bit per architectural register and a vector length. If either source register is tagged as a vector, the two source fields name the first register of each operand, the field that would hold the low branch offset instead names a predicate register, and the block walks element indices from zero up to the vector length minus one. Each cycle it reads one pair of registers through a two-address read port and sets one mask bit when the compare holds. At the end it writes the finished mask to the predicate register in a single cycle.

A source without a vector tag is broadcast: the same register is read for every element, which gives vector-vector, vector-scalar and scalar-vector forms. If neither source is tagged, the instruction is an ordinary branch: the block raises a one-cycle scalar-branch pulse and writes nothing, so that the normal branch unit can handle it. Reserved compare codes and a nonzero upper field in vector mode raise an illegal-instruction pulse instead.

Top module: `pred_cmp_seq`

## Requirements
- R1: After reset `in_ready` is 1 and `pred_we`, `done`, `scalar_branch` and `illegal` are 0. `in_ready` is 1 only while the sequencer is idle, and an instruction is taken on a rising clock edge where `in_valid` and `in_ready` are both 1.
- R2: Only major opcode 1100011 in bits 6..0 is handled. An accepted word with any other opcode causes no write and no flag.
- R3: A branch-opcode word in which neither the register in bits 19..15 nor the register in bits 24..20 has its `vec_tag` bit set raises `scalar_branch` for exactly the one cycle after acceptance and writes no predicate.
- R4: In vector mode `pred_addr` equals bits 11..7 of the accepted word. The first source is in bits 19..15, the second in bits 24..20, and the compare code in bits 14..12.
- R5: Compare codes: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Operand a comes from the first source and operand b from the second.
- R6: In vector mode, compare code 010 or 011, or a nonzero value in bits 31..25, raises `illegal` for exactly the one cycle after acceptance, with no predicate write.
- R7: For element i, a tagged source reads register (base + i) modulo NREG, and an untagged source reads its base register for every element.
- R8: Bit i of the written mask is 1 exactly when the compare of element i holds, for i below the effective length. All higher bits are 0, because the accumulator starts at zero for each instruction.
- R9: The effective length is the requested `vl` clamped to XLEN.
- R10: An effective length of 0 writes an all-zero mask in the first cycle after acceptance.
- R11: A legal vector instruction produces exactly one cycle with `pred_we` and `done` both 1, that cycle being the (length+1)-th cycle after the accepting edge. `in_ready` stays 0 from acceptance until that cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, can take an instruction |
| in_instr | input | 32 | Instruction word |
| vec_tag | input | NREG | Per-register vector tag, sampled at acceptance |
| vl | input | VLW | Requested vector length, sampled at acceptance |
| rd_addr_a | output | log2(NREG) | Register read address, first operand |
| rd_data_a | input | XLEN | Read data for `rd_addr_a`, same cycle |
| rd_addr_b | output | log2(NREG) | Register read address, second operand |
| rd_data_b | input | XLEN | Read data for `rd_addr_b`, same cycle |
| pred_we | output | 1 | Predicate register write strobe |
| pred_addr | output | 5 | Predicate register number |
| pred_data | output | XLEN | Mask written to the predicate register |
| done | output | 1 | Vector compare finished (with the write) |
| scalar_branch | output | 1 | Pulse: the word is an ordinary scalar branch |
| illegal | output | 1 | Pulse: reserved encoding in vector mode |

## Verification
On every cycle the assertions check these properties: the element index stays below the clamped length while sequencing, write strobes never come in two consecutive cycles, no mask bit at or above the length is set, and the illegal and scalar pulses never coincide with a write or with each other. Only the bench scenarios can show that each mask bit matches the right compare of the right register pair (broadcast, wrap-around addressing, signed against unsigned ordering), that the write comes at exactly the expected cycle, and that non-branch opcodes leave no trace at all.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RSVA = 3'b010,
        CMP_RSVB = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        logic       is_branch;
        logic       vec_mode;
        logic       bad;
        cmp_op_e    op;
        logic [4:0] src_a;
        logic [4:0] src_b;
        logic [4:0] dst;
        logic       tag_a;
        logic       tag_b;
    } dec_t;

    function automatic logic op_reserved(input cmp_op_e op);
        return (op == CMP_RSVA) || (op == CMP_RSVB);
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [31:0]     instr,
    input  logic [NREG-1:0] vec_tag,
    output dec_t            dec
);
    logic [4:0] f_rs1, f_rs2, f_rd;
    logic [2:0] f_op;
    logic [6:0] f_hi;
    logic       t_a, t_b, is_br;

    always_comb begin
        f_rd  = instr[11:7];
        f_op  = instr[14:12];
        f_rs1 = instr[19:15];
        f_rs2 = instr[24:20];
        f_hi  = instr[31:25];
        is_br = (instr[6:0] == OPC_BRANCH);
        t_a   = vec_tag[f_rs1[AW-1:0]];
        t_b   = vec_tag[f_rs2[AW-1:0]];

        dec.is_branch = is_br;
        dec.vec_mode  = is_br && (t_a || t_b);
        dec.op        = cmp_op_e'(f_op);
        dec.bad       = dec.vec_mode && (op_reserved(cmp_op_e'(f_op)) || (f_hi != 7'd0));
        dec.src_a     = f_rs1;
        dec.src_b     = f_rs2;
        dec.dst       = f_rd;
        dec.tag_a     = t_a;
        dec.tag_b     = t_b;
    end
endmodule

// File: rtl/pcs_cmp.sv
module pcs_cmp
    import pcs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cmp_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic             hit
);
    logic eq, lt_s, lt_u;

    always_comb begin
        eq   = (a == b);
        lt_s = ($signed(a) < $signed(b));
        lt_u = (a < b);
        unique case (op)
            CMP_EQ:  hit = eq;
            CMP_NE:  hit = !eq;
            CMP_LT:  hit = lt_s;
            CMP_GE:  hit = !lt_s;
            CMP_LTU: hit = lt_u;
            CMP_GEU: hit = !lt_u;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int VLW  = 6,
    localparam int AW   = $clog2(NREG),
    localparam int CNTW = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  dec_t            dec,
    input  logic [VLW-1:0]  vl,
    input  logic            hit,
    output cmp_op_e         op_o,
    output logic [AW-1:0]   rd_addr_a,
    output logic [AW-1:0]   rd_addr_b,
    output logic            pred_we,
    output logic [4:0]      pred_addr,
    output logic [XLEN-1:0] pred_data,
    output logic            done,
    output logic            scalar_branch,
    output logic            illegal
);
    localparam logic [VLW-1:0]  VL_CAP = VLW'(XLEN);

    seq_state_e      state_q;
    logic [CNTW-1:0] idx_q, vl_q, vl_eff;
    logic [XLEN-1:0] mask_q, mask_d, hi_mask;
    cmp_op_e         op_q;
    logic [AW-1:0]   base_a_q, base_b_q;
    logic            tag_a_q, tag_b_q;
    logic [4:0]      dst_q;
    logic            sb_q, ill_q;
    logic            accept;

    always_comb begin
        accept    = in_valid && (state_q == ST_IDLE);
        vl_eff    = (vl > VL_CAP) ? CNTW'(XLEN) : CNTW'(vl);
        mask_d    = mask_q | ({{(XLEN-1){1'b0}}, hit} << idx_q);
        rd_addr_a = base_a_q + (tag_a_q ? AW'(idx_q) : AW'(0));
        rd_addr_b = base_b_q + (tag_b_q ? AW'(idx_q) : AW'(0));
        op_o      = op_q;
        in_ready  = (state_q == ST_IDLE);
        pred_we   = (state_q == ST_WB);
        done      = (state_q == ST_WB);
        pred_addr = dst_q;
        pred_data = (state_q == ST_WB) ? mask_q : '0;
        scalar_branch = sb_q;
        illegal   = ill_q;
        hi_mask   = ~({XLEN{1'b1}} >> (XLEN - int'(vl_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            vl_q     <= '0;
            mask_q   <= '0;
            op_q     <= CMP_EQ;
            base_a_q <= '0;
            base_b_q <= '0;
            tag_a_q  <= 1'b0;
            tag_b_q  <= 1'b0;
            dst_q    <= '0;
            sb_q     <= 1'b0;
            ill_q    <= 1'b0;
        end else begin
            sb_q  <= 1'b0;
            ill_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && dec.is_branch) begin
                        if (!dec.vec_mode) begin
                            sb_q <= 1'b1;
                        end else if (dec.bad) begin
                            ill_q <= 1'b1;
                        end else begin
                            op_q     <= dec.op;
                            base_a_q <= dec.src_a[AW-1:0];
                            base_b_q <= dec.src_b[AW-1:0];
                            tag_a_q  <= dec.tag_a;
                            tag_b_q  <= dec.tag_b;
                            dst_q    <= dec.dst;
                            idx_q    <= '0;
                            mask_q   <= '0;
                            vl_q     <= vl_eff;
                            state_q  <= (vl_eff == '0) ? ST_WB : ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    mask_q <= mask_d;
                    idx_q  <= idx_q + CNTW'(1);
                    if (idx_q == vl_q - CNTW'(1)) state_q <= ST_WB;
                end
                ST_WB: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: index never reaches the clamped length while sequencing
    p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> ((idx_q < vl_q) && (vl_q <= CNTW'(XLEN))));

    // R11: exactly one write cycle per instruction
    p_single_write_r11: assert property (@(posedge clk) disable iff (rst)
        pred_we |=> !pred_we);

    // R8: no bit at or above the length is set
    p_upper_clear_r8: assert property (@(posedge clk) disable iff (rst)
        pred_we |-> ((pred_data & hi_mask) == '0));

    // R6: illegal pulse never with a write or a scalar pulse
    p_illegal_alone_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!pred_we && !scalar_branch));

    // R3: scalar branch pulse leaves the sequencer idle, no write
    p_scalar_idle_r3: assert property (@(posedge clk) disable iff (rst)
        scalar_branch |-> (!pred_we && in_ready));

    // R1: a new word cannot be accepted while busy
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q != ST_IDLE || $past(idx_q) == vl_q - CNTW'(1)) == (state_q != ST_IDLE || 1'b1));

endmodule

// File: rtl/pred_cmp_seq.sv
module pred_cmp_seq
    import pcs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int VLW  = 6,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     in_instr,
    input  logic [NREG-1:0] vec_tag,
    input  logic [VLW-1:0]  vl,
    output logic [AW-1:0]   rd_addr_a,
    input  logic [XLEN-1:0] rd_data_a,
    output logic [AW-1:0]   rd_addr_b,
    input  logic [XLEN-1:0] rd_data_b,
    output logic            pred_we,
    output logic [4:0]      pred_addr,
    output logic [XLEN-1:0] pred_data,
    output logic            done,
    output logic            scalar_branch,
    output logic            illegal
);
    dec_t    dec;
    cmp_op_e op_run;
    logic    hit;

    pcs_decode #(.NREG(NREG)) u_decode (
        .instr   (in_instr),
        .vec_tag (vec_tag),
        .dec     (dec)
    );

    pcs_cmp #(.XLEN(XLEN)) u_cmp (
        .op  (op_run),
        .a   (rd_data_a),
        .b   (rd_data_b),
        .hit (hit)
    );

    pcs_seq #(.XLEN(XLEN), .NREG(NREG), .VLW(VLW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .dec           (dec),
        .vl            (vl),
        .hit           (hit),
        .op_o          (op_run),
        .rd_addr_a     (rd_addr_a),
        .rd_addr_b     (rd_addr_b),
        .pred_we       (pred_we),
        .pred_addr     (pred_addr),
        .pred_data     (pred_data),
        .done          (done),
        .scalar_branch (scalar_branch),
        .illegal       (illegal)
    );

    // R11: write strobe and done always travel together
    p_done_with_write_r11: assert property (@(posedge clk) disable iff (rst)
        done == pred_we);

    // R1: flags are single-cycle pulses
    p_flag_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        (scalar_branch || illegal) |=> !(scalar_branch || illegal));

endmodule

// File: tb/pred_cmp_seq_tb.sv
module pred_cmp_seq_tb;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int VLW  = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_instr;
    logic [31:0] vec_tag;
    logic [5:0]  vl;
    logic [4:0]  rd_addr_a, rd_addr_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        pred_we;
    logic [4:0]  pred_addr;
    logic [31:0] pred_data;
    logic        done, scalar_branch, illegal;

    logic [31:0] rf [NREG];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign rd_data_a = rf[rd_addr_a];
    assign rd_data_b = rf[rd_addr_b];

    pred_cmp_seq #(.XLEN(XLEN), .NREG(NREG), .VLW(VLW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .vec_tag(vec_tag), .vl(vl),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .pred_we(pred_we), .pred_addr(pred_addr), .pred_data(pred_data),
        .done(done), .scalar_branch(scalar_branch), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] s2, input logic [4:0] s1,
                                       input logic [2:0] f3, input logic [4:0] d, input logic [6:0] opc);
        return {f7, s2, s1, f3, d, opc};
    endfunction

    function automatic bit ref_cmp(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'b000: return a == b;
            3'b001: return a != b;
            3'b100: return $signed(a) < $signed(b);
            3'b101: return $signed(a) >= $signed(b);
            3'b110: return a < b;
            3'b111: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_mask(input logic [31:0] ins, input logic [31:0] tags, input int len);
        logic [31:0] m = '0;
        logic [4:0] s1 = ins[19:15];
        logic [4:0] s2 = ins[24:20];
        for (int i = 0; i < len; i++) begin
            logic [4:0] ia = tags[s1] ? 5'(s1 + i) : s1;   // R7 wrap modulo 32
            logic [4:0] ib = tags[s2] ? 5'(s2 + i) : s2;
            if (ref_cmp(ins[14:12], rf[ia], rf[ib])) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic fill_rf();
        for (int i = 0; i < NREG; i++) begin
            case ($urandom_range(0, 5))
                0: rf[i] = 32'd0;
                1: rf[i] = 32'd1;
                2: rf[i] = 32'hFFFF_FFFF;
                3: rf[i] = 32'h8000_0000;
                4: rf[i] = 32'h0000_0003;
                default: rf[i] = $urandom;
            endcase
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] tags, input logic [5:0] vlen);
        bit is_br = (ins[6:0] == 7'b1100011);
        bit vec   = is_br && (tags[ins[19:15]] || tags[ins[24:20]]);
        bit bad   = vec && ((ins[14:12] == 3'b010) || (ins[14:12] == 3'b011) || (ins[31:25] != 7'd0));
        int len   = (vlen > 6'd32) ? 32 : int'(vlen);      // R9
        logic [31:0] exp_m;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready when idle", 64'(in_ready), 64'd1);
        in_instr = ins; vec_tag = tags; vl = vlen; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_instr = $urandom;
        if (!is_br) begin
            for (int k = 0; k < 3; k++) begin
                check(!pred_we && !scalar_branch && !illegal, "R2 other opcode silent",
                      64'({pred_we, scalar_branch, illegal}), 64'd0);
                if (k < 2) @(negedge clk);
            end
        end else if (!vec) begin
            check(scalar_branch && !pred_we && !illegal, "R3 scalar pulse",
                  64'({scalar_branch, pred_we, illegal}), 64'b100);
            @(negedge clk);
            check(!scalar_branch && !pred_we, "R3 pulse one cycle",
                  64'({scalar_branch, pred_we}), 64'd0);
        end else if (bad) begin
            check(illegal && !pred_we && !scalar_branch, "R6 illegal pulse",
                  64'({illegal, pred_we, scalar_branch}), 64'b100);
            @(negedge clk);
            check(!illegal && !pred_we, "R6 no write after illegal",
                  64'({illegal, pred_we}), 64'd0);
        end else begin
            exp_m = ref_mask(ins, tags, len);
            for (int k = 1; k <= len; k++) begin
                check(!pred_we && !in_ready, "R11 busy before write",
                      64'({pred_we, in_ready}), 64'd0);
                @(negedge clk);
            end
            check(pred_we && done, "R11 write and done at length+1",
                  64'({pred_we, done}), 64'b11);
            check(pred_addr == ins[11:7], "R4 predicate address", 64'(pred_addr), 64'(ins[11:7]));
            if (len == 0)
                check(pred_data == 32'd0, "R10 zero length mask", 64'(pred_data), 64'd0);
            else
                check(pred_data == exp_m, "R8 R5 R7 mask value", 64'(pred_data), 64'(exp_m));
            @(negedge clk);
            check(!pred_we && in_ready, "R11 single write then idle",
                  64'({pred_we, in_ready}), 64'b01);
        end
    endtask

    localparam logic [6:0] BR = 7'b1100011;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; vec_tag = '0; vl = '0;
        fill_rf();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(in_ready && !pred_we && !done && !scalar_branch && !illegal, "R1 reset state",
              64'({in_ready, pred_we, done, scalar_branch, illegal}), 64'b10000);

        // directed: vector-scalar equal with broadcast, R7
        rf[3] = 32'd5; rf[4] = 32'd5; rf[5] = 32'd6; rf[6] = 32'd5; rf[10] = 32'd5;
        issue(mk(7'd0, 5'd10, 5'd3, 3'b000, 5'd7, BR), 32'h0000_0008, 6'd4);
        // scalar-vector with wrap-around at the top of the file, R7
        issue(mk(7'd0, 5'd30, 5'd2, 3'b110, 5'd1, BR), 32'h4000_0000, 6'd5);
        // signed versus unsigned on -1 and 1, R5
        rf[12] = 32'hFFFF_FFFF; rf[13] = 32'd1;
        issue(mk(7'd0, 5'd13, 5'd12, 3'b100, 5'd2, BR), 32'h0000_1000, 6'd1);
        issue(mk(7'd0, 5'd13, 5'd12, 3'b110, 5'd2, BR), 32'h0000_1000, 6'd1);
        issue(mk(7'd0, 5'd13, 5'd12, 3'b101, 5'd2, BR), 32'h0000_1000, 6'd1);
        issue(mk(7'd0, 5'd13, 5'd12, 3'b111, 5'd2, BR), 32'h0000_1000, 6'd1);
        // zero length, R10
        issue(mk(7'd0, 5'd1, 5'd2, 3'b001, 5'd9, BR), 32'h0000_0004, 6'd0);
        // over-long length clamps, R9
        issue(mk(7'd0, 5'd0, 5'd0, 3'b000, 5'd31, BR), 32'h0000_0001, 6'd63);
        // scalar branch, R3
        issue(mk(7'd0, 5'd1, 5'd2, 3'b000, 5'd4, BR), 32'h0000_0000, 6'd8);
        // reserved code and reserved upper field, R6
        issue(mk(7'd0, 5'd1, 5'd2, 3'b010, 5'd4, BR), 32'h0000_0002, 6'd8);
        issue(mk(7'd0, 5'd1, 5'd2, 3'b011, 5'd4, BR), 32'h0000_0004, 6'd8);
        issue(mk(7'd1, 5'd1, 5'd2, 3'b000, 5'd4, BR), 32'h0000_0004, 6'd8);
        // non-branch opcode, R2
        issue(mk(7'd0, 5'd1, 5'd2, 3'b000, 5'd4, 7'b0110011), 32'hFFFF_FFFF, 6'd8);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [6:0] f7  = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(1, 127)) : 7'd0;
            logic [6:0] opc = ($urandom_range(0, 14) == 0) ? 7'b0010011 : BR;
            logic [2:0] f3  = 3'($urandom);
            logic [31:0] tg = ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom;
            logic [5:0] len = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(33, 63))
                                                          : 6'($urandom_range(0, 32));
            if (n % 25 == 0) fill_rf();
            issue(mk(f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), opc), tg, len);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule